// File: doc/BRIEF.md
# Video-RAM Block Copier

This block moves data from anywhere in a 16-bit address space into the video-RAM window, 16 bytes at a time, by acting as a bus master. Software programs a source address, a destination offset and a control byte through five byte-wide registers. The control byte holds a chunk count and a mode bit. In burst mode the whole copy runs at once while the processor is held off. In line-gap mode one 16-byte chunk moves for each horizontal-blank pulse that arrives while the video mode input reads 0.

Writing the control byte starts a copy. Before any byte moves, the block aligns the source and destination to 16-byte boundaries and forces the destination into the video-RAM window. A source that points into video RAM itself is refused. Each byte takes one read cycle followed by one write cycle. At the end of every chunk the advanced addresses are written back into the address registers, and the control register shows the chunks left or 0xFF when the block is idle.

States: `ST_IDLE` (no copy pending), `ST_ARMED` (line-gap mode waiting for a pulse), `ST_READ` (source read issued), `ST_WRITE` (destination write issued). The transitions are:
- IDLE→READ on an accepted control write that starts at once.
- IDLE→ARMED on a line-gap write outside mode 0.
- ARMED→READ on a qualified pulse or an immediate restart.
- ARMED→ARMED on a re-arm.
- ARMED→IDLE on cancel.
- READ→WRITE always.
- WRITE→READ within a chunk, or to the next chunk in burst mode.
- WRITE→ARMED after a chunk in line-gap mode with chunks left.
- WRITE→IDLE after the last chunk.

Top module: `vdma_ctrl`

## Requirements
- R1: After reset the control register (select 4) reads 0xFF, address registers (selects 0..3) read 0x00, `cpu_stall`, `bus_rd` and `bus_wr` are low.
- R2: Selects 0/1 hold the source high/low byte and selects 2/3 the destination high/low byte. A write to one of them while not copying is read back unchanged.
- R3: A control write latches source = {sel0,sel1} AND 0xFFF0 and destination = ({sel2,sel3} AND 0x1FF0) OR 0x8000.
- R4: If the aligned source lies in 0x8000–0x9FFF, the control write is refused: no bus activity, no stall, and the control register keeps its previous value.
- R5: Control write bits [6:0] = n give a copy length of (n+1)×16 bytes. Bit 7 = 1 selects line-gap mode and bit 7 = 0 selects burst mode.
- R6: Each byte is a read of the source address, followed in the next cycle by a write of the read data to the destination address. Both addresses step by one per byte, and `cpu_stall` is high for exactly 32 cycles per chunk.
- R7: A burst-mode write starts immediately, whatever the video mode, when line-gap mode is not active. When it finishes, the stall is released and the control register reads 0xFF.
- R8: After each chunk the address registers hold the advanced source and destination addresses.
- R9: A line-gap write with video mode ≠ 0 moves nothing and the control register reads n with bit 7 clear. With video mode 0 the first chunk moves at once.
- R10: While armed, each pulse with video mode 0 moves one chunk and decrements the control register. Pulses with video mode ≠ 0 move nothing. After the final chunk the register reads 0xFF and further pulses move nothing.
- R11: A burst-mode write while line-gap mode is armed and video mode ≠ 0 cancels the copy: nothing moves, the register reads 0xFF, and later pulses move nothing.
- R12: A control write and a qualified pulse in the same cycle start exactly one chunk.
- R13: Register writes (any select) while a copy is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..4) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| vid_mode | input | 2 | Current video mode; 0 is the line gap |
| hblank_pulse | input | 1 | One-cycle horizontal-blank pulse |
| cpu_stall | output | 1 | Holds the processor while bytes move |
| bus_addr | output | 16 | Bus master address |
| bus_rd | output | 1 | Bus read request; data returns next cycle |
| bus_wr | output | 1 | Bus write request |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, one cycle after `bus_rd` |

## Verification
The two events that can collide are a control-register write and a qualified horizontal-blank pulse. The bench provokes this by arming line-gap mode, then in one cycle switching the video mode to 0, raising the pulse and writing a new control byte. The result is judged from the ports. Exactly 16 bytes must move at the expected addresses, and the control register must then show the new count minus one. A double start would show up as 32 bytes moved and a count that is one lower.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int unsigned ADDR_W      = 16;
    localparam int unsigned DATA_W      = 8;
    localparam int unsigned CHUNK_BYTES = 16;
    localparam int unsigned LEN_W       = 7;
    localparam int unsigned VRAM_BASE   = 32'h8000;
    localparam int unsigned VRAM_SPAN   = 32'h2000;

    localparam logic [1:0] VMODE_LINE_GAP = 2'd0;

    localparam logic [2:0] SEL_SRC_HI = 3'd0;
    localparam logic [2:0] SEL_SRC_LO = 3'd1;
    localparam logic [2:0] SEL_DST_HI = 3'd2;
    localparam logic [2:0] SEL_DST_LO = 3'd3;
    localparam logic [2:0] SEL_CTRL   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dma_state_e;

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          busy,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_src,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] ctrl_view,
    output logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] src_cfg,
    output logic [AW-1:0] dst_cfg
);

    logic [AW-1:0] src_r;
    logic [AW-1:0] dst_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_r <= '0;
            dst_r <= '0;
        end else if (wb_en) begin
            src_r <= wb_src;
            dst_r <= wb_dst;
        end else if (reg_wr && !busy) begin
            case (reg_sel)
                SEL_SRC_HI: src_r[AW-1:DW] <= reg_wdata;
                SEL_SRC_LO: src_r[DW-1:0]  <= reg_wdata;
                SEL_DST_HI: dst_r[AW-1:DW] <= reg_wdata;
                SEL_DST_LO: dst_r[DW-1:0]  <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_SRC_HI: reg_rdata = src_r[AW-1:DW];
            SEL_SRC_LO: reg_rdata = src_r[DW-1:0];
            SEL_DST_HI: reg_rdata = dst_r[AW-1:DW];
            SEL_DST_LO: reg_rdata = dst_r[DW-1:0];
            SEL_CTRL:   reg_rdata = ctrl_view;
            default:    reg_rdata = '1;
        endcase
    end

    assign src_cfg = src_r;
    assign dst_cfg = dst_r;

    // R8
    wb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (src_r == $past(wb_src)) && (dst_r == $past(wb_dst)));

    // R13
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_en) |=> ($stable(src_r) && $stable(dst_r)));

endmodule

// File: rtl/vdma_addr.sv
module vdma_addr
    import vdma_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned CHUNK = CHUNK_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] src_cfg,
    input  logic [AW-1:0] dst_cfg,
    input  logic          rd_phase,
    input  logic          wr_phase,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic [AW-1:0] wb_src,
    output logic [AW-1:0] wb_dst,
    output logic          src_bad
);

    localparam logic [AW-1:0] ALIGN_MASK   = ~AW'(CHUNK - 1);
    localparam logic [AW-1:0] DST_OFF_MASK = AW'(VRAM_SPAN - 1) & ALIGN_MASK;
    localparam logic [AW-1:0] DST_BASE     = AW'(VRAM_BASE);

    logic [AW-1:0] src_aligned;
    logic [AW-1:0] dst_aligned;
    logic [AW-1:0] src_ptr_q;
    logic [AW-1:0] dst_ptr_q;
    logic [31:0]   src_wide;

    always_comb begin
        src_aligned = src_cfg & ALIGN_MASK;
        dst_aligned = (dst_cfg & DST_OFF_MASK) | DST_BASE;
        src_wide    = 32'(src_aligned);
        src_bad     = (src_wide >= VRAM_BASE) && (src_wide < VRAM_BASE + VRAM_SPAN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr_q <= '0;
            dst_ptr_q <= DST_BASE;
        end else if (load) begin
            src_ptr_q <= src_aligned;
            dst_ptr_q <= dst_aligned;
        end else begin
            if (rd_phase) src_ptr_q <= src_ptr_q + 1'b1;
            if (wr_phase) dst_ptr_q <= dst_ptr_q + 1'b1;
        end
    end

    always_comb begin
        bus_addr  = wr_phase ? dst_ptr_q : src_ptr_q;
        bus_rd    = rd_phase;
        bus_wr    = wr_phase;
        bus_wdata = bus_rdata;
        wb_src    = src_ptr_q;
        wb_dst    = dst_ptr_q + 1'b1;
    end

    // R6
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase && !load) |=> src_ptr_q == $past(src_ptr_q) + 1'b1);

    // R3
    load_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (src_ptr_q[3:0] == 4'd0) && (dst_ptr_q[3:0] == 4'd0) &&
                 (dst_ptr_q[AW-1:13] == 3'b100));

endmodule

// File: rtl/vdma_fsm.sv
module vdma_fsm
    import vdma_pkg::*;
#(
    parameter int unsigned CHUNK = CHUNK_BYTES,
    parameter int unsigned LW    = LEN_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [LW:0] ctrl_wdata,
    input  logic [1:0]  vid_mode,
    input  logic        hblank_pulse,
    input  logic        src_bad,
    output logic        load_ptrs,
    output logic        rd_phase,
    output logic        wr_phase,
    output logic        chunk_done,
    output logic        busy,
    output logic [LW:0] ctrl_view
);

    localparam int unsigned CNT_W = $clog2(CHUNK);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHUNK - 1);

    dma_state_e       state_q, state_d;
    logic [LW:0]      len_q;
    logic             hb_active_q;
    logic [CNT_W-1:0] byte_cnt_q;

    logic in_window, new_hb, accept, go_now, cancel, hb_start, last_byte, len_zero;

    always_comb begin
        in_window = (vid_mode == VMODE_LINE_GAP);
        new_hb    = ctrl_wdata[LW];
        accept    = ctrl_wr && !src_bad && ((state_q == ST_IDLE) || (state_q == ST_ARMED));
        go_now    = (!hb_active_q && !new_hb) || in_window;
        cancel    = accept && !new_hb && hb_active_q && !go_now;
        hb_start  = (state_q == ST_ARMED) && !accept && hblank_pulse && in_window;
        last_byte = (state_q == ST_WRITE) && (byte_cnt_q == LAST_CNT);
        len_zero  = (len_q == '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ARMED: begin
                if (accept) begin
                    if (go_now)      state_d = ST_READ;
                    else if (new_hb) state_d = ST_ARMED;
                    else             state_d = ST_IDLE;
                end else if (hb_start) begin
                    state_d = ST_READ;
                end
            end
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: begin
                if (!last_byte)       state_d = ST_READ;
                else if (len_zero)    state_d = ST_IDLE;
                else if (hb_active_q) state_d = ST_ARMED;
                else                  state_d = ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q       <= '1;
            hb_active_q <= 1'b0;
            byte_cnt_q  <= '0;
        end else if (accept) begin
            hb_active_q <= new_hb;
            len_q       <= cancel ? '1 : {1'b0, ctrl_wdata[LW-1:0]};
            byte_cnt_q  <= '0;
        end else if (hb_start) begin
            byte_cnt_q  <= '0;
        end else if (state_q == ST_WRITE) begin
            byte_cnt_q <= last_byte ? '0 : byte_cnt_q + 1'b1;
            if (last_byte) begin
                len_q <= len_q - 1'b1;
                if (len_zero) hb_active_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_phase   = (state_q == ST_READ);
        wr_phase   = (state_q == ST_WRITE);
        busy       = rd_phase || wr_phase;
        chunk_done = last_byte;
        load_ptrs  = accept;
        ctrl_view  = (state_q == ST_IDLE) ? '1 : {1'b0, len_q[LW-1:0]};
    end

    // R6
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q == ST_WRITE));

    // R7
    final_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && len_zero) |=> (state_q == ST_IDLE) && (len_q == '1) && !hb_active_q);

    // R4
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && src_bad && state_q == ST_IDLE) |=> (state_q == ST_IDLE) && $stable(len_q));

    // R10
    hb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !ctrl_wr && !in_window) |=> (state_q == ST_ARMED));

    // R12
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hblank_pulse && in_window) |=> (state_q == ST_READ) && (byte_cnt_q == '0));

endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
    import vdma_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned CHUNK = CHUNK_BYTES,
    parameter int unsigned LW    = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [1:0]    vid_mode,
    input  logic          hblank_pulse,
    output logic          cpu_stall,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);

    logic          ctrl_wr;
    logic          load_ptrs, rd_phase, wr_phase, chunk_done, busy, src_bad;
    logic [LW:0]   ctrl_view;
    logic [AW-1:0] src_cfg, dst_cfg, wb_src, wb_dst;

    assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
    assign cpu_stall = busy;

    vdma_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .wb_en     (chunk_done),
        .wb_src    (wb_src),
        .wb_dst    (wb_dst),
        .ctrl_view (DW'(ctrl_view)),
        .reg_rdata (reg_rdata),
        .src_cfg   (src_cfg),
        .dst_cfg   (dst_cfg)
    );

    vdma_addr #(.AW(AW), .DW(DW), .CHUNK(CHUNK)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ptrs),
        .src_cfg   (src_cfg),
        .dst_cfg   (dst_cfg),
        .rd_phase  (rd_phase),
        .wr_phase  (wr_phase),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .wb_src    (wb_src),
        .wb_dst    (wb_dst),
        .src_bad   (src_bad)
    );

    vdma_fsm #(.CHUNK(CHUNK), .LW(LW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (reg_wdata[LW:0]),
        .vid_mode     (vid_mode),
        .hblank_pulse (hblank_pulse),
        .src_bad      (src_bad),
        .load_ptrs    (load_ptrs),
        .rd_phase     (rd_phase),
        .wr_phase     (wr_phase),
        .chunk_done   (chunk_done),
        .busy         (busy),
        .ctrl_view    (ctrl_view)
    );

    // R6
    one_bus_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R6
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));

endmodule

// File: tb/vdma_ctrl_test.sv
`timescale 1ns/1ps
module vdma_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [1:0]  vid_mode = 2'd2;
    logic        hblank_pulse = 1'b0;
    logic        cpu_stall;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'd0;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] exp_src, exp_dst;
    int bytes, stall_cyc, bad;

    always #4 clk = ~clk;

    vdma_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vid_mode(vid_mode),
        .hblank_pulse(hblank_pulse), .cpu_stall(cpu_stall), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
    endfunction

    always @(posedge clk) if (bus_rd) bus_rdata <= pat(bus_addr);

    task automatic chk(input string req, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (bus_rd && bus_addr !== exp_src) bad++;
        if (bus_wr) begin
            if (bus_addr !== exp_dst || bus_wdata !== pat(exp_src)) bad++;
            exp_src++;
            exp_dst++;
            bytes++;
        end
        if (cpu_stall) stall_cyc++;
    endtask

    task automatic watch(input int n);
        repeat (n) tick();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] val);
        tick();
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rdr(input logic [2:0] sel, output logic [7:0] v);
        tick();
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic set_mode(input logic [1:0] m);
        tick();
        vid_mode = m;
    endtask

    task automatic pulse();
        tick();
        hblank_pulse = 1'b1;
        tick();
        hblank_pulse = 1'b0;
    endtask

    task automatic clear_obs(input logic [15:0] s, input logic [15:0] d);
        exp_src = s & 16'hFFF0;
        exp_dst = (d & 16'h1FF0) | 16'h8000;
        bytes = 0; stall_cyc = 0; bad = 0;
    endtask

    task automatic load_addr(input logic [15:0] s, input logic [15:0] d);
        wr(3'd0, s[15:8]); wr(3'd1, s[7:0]);
        wr(3'd2, d[15:8]); wr(3'd3, d[7:0]);
    endtask

    task automatic chk_ctrl(input string req, input int expv);
        logic [7:0] v;
        rdr(3'd4, v);
        chk(req, int'(v), expv);
    endtask

    task automatic chk_regs(input string req);
        logic [7:0] h, l;
        rdr(3'd0, h); rdr(3'd1, l);
        chk(req, int'({h, l}), int'(exp_src));
        rdr(3'd2, h); rdr(3'd3, l);
        chk(req, int'({h, l}), int'(exp_dst));
    endtask

    task automatic run_general(input logic [15:0] s, input logic [15:0] d, input logic [6:0] n);
        clear_obs(s, d);
        load_addr(s, d);
        wr(3'd4, {1'b0, n});
        watch(32 * (int'(n) + 1) + 4);
        chk("R5 bytes moved", bytes, 16 * (int'(n) + 1));
        chk("R3/R6 address or data mismatches", bad, 0);
        chk("R6 stall cycles", stall_cyc, 32 * (int'(n) + 1));
        chk("R7 stall released", int'(cpu_stall), 0);
        chk_ctrl("R7 control after burst", 8'hFF);
        chk_regs("R8 write-back");
    endtask

    initial begin
        logic [7:0] v;
        logic [15:0] s, d;
        void'($urandom(32'd20240611));
        exp_src = 16'd0; exp_dst = 16'h8000; bytes = 0; stall_cyc = 0; bad = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 stall", int'(cpu_stall), 0);
        chk("R1 bus idle", int'(bus_rd | bus_wr), 0);
        chk_ctrl("R1 control", 8'hFF);
        for (int i = 0; i < 4; i++) begin
            rdr(3'(i), v);
            chk("R1 address reg", int'(v), 0);
        end

        // R2 register readback
        load_addr(16'hA5C3, 16'h3C96);
        rdr(3'd0, v); chk("R2 src hi", int'(v), 8'hA5);
        rdr(3'd1, v); chk("R2 src lo", int'(v), 8'hC3);
        rdr(3'd2, v); chk("R2 dst hi", int'(v), 8'h3C);
        rdr(3'd3, v); chk("R2 dst lo", int'(v), 8'h96);

        // R3 R5 R7: directed bursts including alignment and bounds
        run_general(16'h7FFF, 16'hFFFF, 7'd0);
        run_general(16'hA00B, 16'h0123, 7'd1);
        set_mode(2'd0);
        run_general(16'hC010, 16'h0000, 7'd2);
        set_mode(2'd3);
        run_general(16'h0000, 16'h0000, 7'd127);

        // R4 refused source inside video RAM
        clear_obs(16'h8800, 16'h0000);
        load_addr(16'h8800, 16'h0000);
        wr(3'd4, 8'h03);
        watch(40);
        chk("R4 no bytes", bytes, 0);
        chk("R4 no stall", stall_cyc, 0);
        chk_ctrl("R4 control unchanged", 8'hFF);
        load_addr(16'h9FFF, 16'h0000);
        wr(3'd4, 8'h80);
        watch(40);
        chk("R4 upper edge no bytes", bytes, 0);
        chk_ctrl("R4 upper edge control", 8'hFF);

        // R9 R10 line-gap mode
        set_mode(2'd3);
        clear_obs(16'h1234, 16'h0040);
        load_addr(16'h1234, 16'h0040);
        wr(3'd4, 8'h82);
        watch(40);
        chk("R9 armed no bytes", bytes, 0);
        chk("R9 armed no stall", stall_cyc, 0);
        chk_ctrl("R9 armed count", 8'h02);
        pulse(); watch(40);
        chk("R10 pulse outside mode 0", bytes, 0);
        set_mode(2'd0);
        pulse(); watch(40);
        chk("R10 first chunk", bytes, 16);
        chk("R10 chunk stall", stall_cyc, 32);
        chk_ctrl("R10 count after one", 8'h01);
        chk_regs("R8 write-back after chunk");
        set_mode(2'd2); set_mode(2'd0);
        pulse(); watch(40);
        chk("R10 second chunk", bytes, 32);
        chk_ctrl("R10 count after two", 8'h00);
        pulse(); watch(40);
        chk("R10 third chunk", bytes, 48);
        chk_ctrl("R10 idle after last", 8'hFF);
        pulse(); watch(40);
        chk("R10 no chunk after end", bytes, 48);
        chk("R6 line-gap data", bad, 0);

        // R9 immediate start in mode 0
        clear_obs(16'h2200, 16'h0300);
        load_addr(16'h2200, 16'h0300);
        wr(3'd4, 8'h83);
        watch(40);
        chk("R9 immediate chunk", bytes, 16);
        chk_ctrl("R9 immediate count", 8'h02);
        set_mode(2'd3);
        wr(3'd4, 8'h00);
        watch(40);
        chk("R11 cancel no bytes", bytes, 16);
        chk_ctrl("R11 cancel control", 8'hFF);

        // R11 cancel of a fresh arm
        clear_obs(16'h3300, 16'h0500);
        load_addr(16'h3300, 16'h0500);
        wr(3'd4, 8'h85);
        wr(3'd4, 8'h05);
        chk_ctrl("R11 control after cancel", 8'hFF);
        set_mode(2'd0);
        pulse(); watch(40);
        chk("R11 pulse after cancel", bytes, 0);

        // R12 control write and pulse in the same cycle
        set_mode(2'd3);
        clear_obs(16'h4560, 16'h0200);
        load_addr(16'h4560, 16'h0200);
        wr(3'd4, 8'h84);
        tick();
        vid_mode = 2'd0; reg_sel = 3'd4; reg_wdata = 8'h81; reg_wr = 1'b1; hblank_pulse = 1'b1;
        tick();
        reg_wr = 1'b0; hblank_pulse = 1'b0;
        watch(60);
        chk("R12 exactly one chunk", bytes, 16);
        chk_ctrl("R12 count", 8'h00);
        pulse(); watch(40);
        chk("R12 follow-up chunk", bytes, 32);
        chk_ctrl("R12 idle", 8'hFF);
        chk("R12 data", bad, 0);

        // R13 writes during a copy are ignored
        set_mode(2'd1);
        clear_obs(16'h5000, 16'h0800);
        load_addr(16'h5000, 16'h0800);
        wr(3'd4, 8'h03);
        watch(10);
        wr(3'd0, 8'hEE);
        wr(3'd4, 8'h80);
        watch(140);
        chk("R13 bytes unaffected", bytes, 64);
        chk_ctrl("R13 control", 8'hFF);
        chk_regs("R13 address regs");

        // random bursts
        for (int k = 0; k < 10; k++) begin
            s = 16'($urandom);
            if (s[15:13] == 3'b100) s[15] = 1'b0;
            d = 16'($urandom);
            set_mode(2'($urandom));
            run_general(s, d, 7'($urandom % 8));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

endmodule